// File: doc/BRIEF.md
# Memory-Reference Effective Address Generator

This block forms the effective address of a load or store from a decoded memory-reference descriptor. It receives a base register number and its value, an index register number and its value, a left-shift scale, a displacement word taken from the instruction stream together with its size selector, the current instruction pointer, and a flag that tells the short encoding from the extended one. The result is a 64-bit address and a flag that says whether the instruction pointer stood in for the base register.

Register number zero is read by position. In the base slot it stands for the instruction pointer. In the index slot of the extended form it stands for the value zero. The short form adds a sign-extended 16-bit immediate to the base and has no index term. The extended form adds the base, an optional scaled index and an optional 32-bit or 64-bit displacement. The arithmetic is combinational and ends in one output register stage with a valid bit.

Top module: `mref_agen`

## Requirements
- R1: When `ext_form` is 0 (short form), the address is base plus the sign-extended `disp_word[15:0]`. `idx_spec`, `idx_val`, `scale` and `disp_sel` have no effect on it.
- R2: When `base_spec` is 0, `ip` replaces `base_val` as the base in both forms and `ip_rel` is 1. For any other `base_spec`, `base_val` is the base and `ip_rel` is 0.
- R3: In the extended form, an `idx_spec` of 0 makes the index term zero, whatever `idx_val` holds.
- R4: In the extended form, with `idx_spec` nonzero, the index term is `idx_val` shifted left by `scale` (0 to 3, a factor of 1, 2, 4 or 8). Bits shifted out above bit 63 are dropped.
- R5: In the extended form, `disp_sel` picks the displacement: 2'b00 none (zero), 2'b01 `disp_word[31:0]`, 2'b10 or 2'b11 the whole 64-bit `disp_word`.
- R6: The 16-bit and 32-bit displacements are sign-extended to 64 bits before the addition.
- R7: All additions wrap modulo 2^64.
- R8: A cycle with `in_valid` high makes `out_valid` high in the following cycle, with `ea` and `ip_rel` for that request. A cycle with `in_valid` low makes `out_valid` low in the following cycle and leaves `ea` and `ip_rel` unchanged.
- R9: Synchronous reset clears `out_valid`, `ea` and `ip_rel` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request valid |
| ext_form | input | 1 | 1 for the extended encoding, 0 for the short one |
| base_spec | input | 5 | Base register number; 0 selects the instruction pointer |
| base_val | input | 64 | Value of the base register |
| idx_spec | input | 5 | Index register number; 0 gives a zero index |
| idx_val | input | 64 | Value of the index register |
| scale | input | 2 | Index left-shift amount |
| disp_sel | input | 2 | Extended-form displacement size |
| disp_word | input | 64 | Displacement bits from the instruction stream |
| ip | input | 64 | Current instruction pointer |
| out_valid | output | 1 | Registered result valid |
| ea | output | 64 | Registered effective address |
| ip_rel | output | 1 | Registered flag: the base was the instruction pointer |

## Verification
The assertions assume that the descriptor fields hold steady for the whole cycle in which `in_valid` is sampled. They also assume that `scale` and `disp_sel` carry only the codes listed above, which their 2-bit widths already guarantee. The bench changes every input only at the falling edge. About one specifier in four is drawn as zero, so both uses of register zero come up often. Every form, scale and displacement size is drawn, including values near the top of the address range that force wrap-around.

// File: rtl/agen_pkg.sv
package agen_pkg;
  // Extended-form displacement size codes
  typedef enum logic [1:0] {
    DSP_NONE = 2'b00,
    DSP_W32  = 2'b01,
    DSP_W64A = 2'b10,
    DSP_W64B = 2'b11
  } dsp_kind_t;

  localparam int unsigned SHORT_DISP_W = 16;
  localparam int unsigned MID_DISP_W   = 32;
endpackage

// File: rtl/agen_base_sel.sv
module agen_base_sel #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SPEC_W = 5
) (
  input  logic [SPEC_W-1:0] spec,
  input  logic [ADDR_W-1:0] reg_val,
  input  logic [ADDR_W-1:0] ip,
  output logic [ADDR_W-1:0] base_term,
  output logic              used_ip
);
  // Register number zero in the base slot means the instruction pointer
  always_comb begin
    used_ip   = (spec == '0);
    base_term = used_ip ? ip : reg_val;
  end
endmodule

// File: rtl/agen_index_scale.sv
module agen_index_scale #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned SPEC_W  = 5,
  parameter int unsigned SCALE_W = 2
) (
  input  logic               enable,
  input  logic [SPEC_W-1:0]  spec,
  input  logic [ADDR_W-1:0]  reg_val,
  input  logic [SCALE_W-1:0] scale,
  output logic [ADDR_W-1:0]  idx_term
);
  localparam int unsigned NSHIFT = 1 << SCALE_W;

  logic [ADDR_W-1:0] shifted [NSHIFT];

  // One shifted copy per scale code; the scale picks one
  for (genvar s = 0; s < NSHIFT; s++) begin : g_shift
    assign shifted[s] = reg_val << s;
  end

  always_comb begin
    if (!enable || spec == '0) idx_term = '0;
    else                       idx_term = shifted[scale];
  end
endmodule

// File: rtl/agen_disp_ext.sv
module agen_disp_ext
  import agen_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic              ext_form,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] word,
  output logic [ADDR_W-1:0] disp_term
);
  localparam int unsigned S_PAD = ADDR_W - SHORT_DISP_W;
  localparam int unsigned M_PAD = ADDR_W - MID_DISP_W;

  logic [ADDR_W-1:0] sx_short, sx_mid;
  dsp_kind_t         kind;

  assign sx_short = {{S_PAD{word[SHORT_DISP_W-1]}}, word[SHORT_DISP_W-1:0]};
  assign sx_mid   = {{M_PAD{word[MID_DISP_W-1]}}, word[MID_DISP_W-1:0]};
  assign kind     = dsp_kind_t'(sel);

  always_comb begin
    if (!ext_form) begin
      disp_term = sx_short;
    end else begin
      unique case (kind)
        DSP_NONE: disp_term = '0;
        DSP_W32:  disp_term = sx_mid;
        default:  disp_term = word;
      endcase
    end
  end
endmodule

// File: rtl/mref_agen.sv
module mref_agen #(
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned SPEC_W  = 5,
  parameter int unsigned SCALE_W = 2,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               ext_form,
  input  logic [SPEC_W-1:0]  base_spec,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic [SPEC_W-1:0]  idx_spec,
  input  logic [ADDR_W-1:0]  idx_val,
  input  logic [SCALE_W-1:0] scale,
  input  logic [1:0]         disp_sel,
  input  logic [ADDR_W-1:0]  disp_word,
  input  logic [ADDR_W-1:0]  ip,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  ea,
  output logic               ip_rel
);
  logic [ADDR_W-1:0] base_term, idx_term, disp_term, sum_c;
  logic              used_ip;

  agen_base_sel #(.ADDR_W(ADDR_W), .SPEC_W(SPEC_W)) u_base (
    .spec(base_spec), .reg_val(base_val), .ip(ip),
    .base_term(base_term), .used_ip(used_ip)
  );

  agen_index_scale #(.ADDR_W(ADDR_W), .SPEC_W(SPEC_W), .SCALE_W(SCALE_W)) u_idx (
    .enable(ext_form), .spec(idx_spec), .reg_val(idx_val), .scale(scale),
    .idx_term(idx_term)
  );

  agen_disp_ext #(.ADDR_W(ADDR_W)) u_disp (
    .ext_form(ext_form), .sel(disp_sel), .word(disp_word),
    .disp_term(disp_term)
  );

  // Three-input sum, carries past the top bit discarded
  assign sum_c = base_term + idx_term + disp_term;

  // Short form never carries an index term
  AST_SHORT_NO_IDX: assert property (@(posedge clk) disable iff (rst)
    !ext_form |-> idx_term == '0); // R1
  // Zero index register contributes nothing
  AST_IDX_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ext_form && idx_spec == '0) |-> idx_term == '0); // R3
  // Scaled index has its low scale bits clear
  AST_SCALE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    ext_form |-> (idx_term & ((ADDR_W'(1) << scale) - ADDR_W'(1))) == '0); // R4
  // Short displacement upper bits copy bit 15
  AST_DISP_SEXT: assert property (@(posedge clk) disable iff (rst)
    !ext_form |-> (disp_term[ADDR_W-1:15] == '0 || disp_term[ADDR_W-1:15] == '1)); // R6

  if (REG_OUT) begin : g_reg
    logic              vld_q, iprel_q;
    logic [ADDR_W-1:0] ea_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q   <= 1'b0;
        ea_q    <= '0;
        iprel_q <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) begin
          ea_q    <= sum_c;
          iprel_q <= used_ip;
        end
      end
    end

    assign out_valid = vld_q;
    assign ea        = ea_q;
    assign ip_rel    = iprel_q;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R8
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(ea) && $stable(ip_rel))); // R8
    AST_IP_FLAG: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ip_rel == $past(base_spec == '0)); // R2
  end else begin : g_comb
    assign out_valid = in_valid;
    assign ea        = sum_c;
    assign ip_rel    = used_ip;
  end
endmodule

// File: tb/tb_mref_agen.sv
module tb_mref_agen;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, ext_form;
  logic [4:0]  base_spec, idx_spec;
  logic [63:0] base_val, idx_val, disp_word, ip;
  logic [1:0]  scale, disp_sel;
  logic        out_valid, ip_rel;
  logic [63:0] ea;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mref_agen dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ext_form(ext_form),
    .base_spec(base_spec), .base_val(base_val), .idx_spec(idx_spec),
    .idx_val(idx_val), .scale(scale), .disp_sel(disp_sel),
    .disp_word(disp_word), .ip(ip), .out_valid(out_valid), .ea(ea),
    .ip_rel(ip_rel)
  );

  function automatic logic [63:0] model_ea(
    logic e, logic [4:0] bs, logic [63:0] bv, logic [4:0] is,
    logic [63:0] iv, logic [1:0] sc, logic [1:0] ds, logic [63:0] dw,
    logic [63:0] p);
    logic [63:0] b, x, d;
    b = (bs == 0) ? p : bv;
    if (!e) begin
      x = 0;
      d = {{48{dw[15]}}, dw[15:0]};
    end else begin
      x = (is == 0) ? 64'd0 : (iv << sc);
      case (ds)
        2'b00:   d = 0;
        2'b01:   d = {{32{dw[31]}}, dw[31:0]};
        default: d = dw;
      endcase
    end
    return b + x + d;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one request at the falling edge, check it one cycle later
  task automatic req(string tag, logic e, logic [4:0] bs, logic [63:0] bv,
                     logic [4:0] is, logic [63:0] iv, logic [1:0] sc,
                     logic [1:0] ds, logic [63:0] dw, logic [63:0] p);
    logic [63:0] exp;
    @(negedge clk);
    in_valid = 1; ext_form = e; base_spec = bs; base_val = bv;
    idx_spec = is; idx_val = iv; scale = sc; disp_sel = ds;
    disp_word = dw; ip = p;
    exp = model_ea(e, bs, bv, is, iv, sc, ds, dw, p);
    @(negedge clk);
    in_valid = 0;
    chk({tag, " R8 valid"}, {63'd0, out_valid}, 64'd1);
    chk({tag, " ea"}, ea, exp);
    chk({tag, " R2 ip_rel"}, {63'd0, ip_rel}, {63'd0, bs == 0});
  endtask

  function automatic logic [4:0] rspec();
    return ($urandom % 4 == 0) ? 5'd0 : 5'($urandom);
  endfunction

  initial begin
    #(5ns * 50000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held_ea;
    logic        held_ip;
    void'($urandom(32'd1234));
    rst = 1; in_valid = 1; ext_form = 1; base_spec = 0; base_val = 64'h55;
    idx_spec = 3; idx_val = 7; scale = 2; disp_sel = 2; disp_word = 64'hF0;
    ip = 64'h1000;
    repeat (3) @(negedge clk);
    // R9 reset clears outputs even with a request present
    chk("R9 out_valid", {63'd0, out_valid}, 64'd0);
    chk("R9 ea", ea, 64'd0);
    chk("R9 ip_rel", {63'd0, ip_rel}, 64'd0);
    in_valid = 0;
    rst = 0;

    // R1: short form, index fields and disp_sel must not matter
    req("R1 short pos", 0, 5'd4, 64'h1000, 5'd7, 64'hFFFF, 2'd3, 2'd2, 64'hABCD_0010, 64'h9);
    // R6: short negative immediate
    req("R6 short neg", 0, 5'd4, 64'h1000, 5'd0, 64'h0, 2'd0, 2'd0, 64'h0000_FFF0, 64'h9);
    // R2: base zero uses ip in short and extended forms
    req("R2 short ip", 0, 5'd0, 64'hDEAD, 5'd1, 64'h5, 2'd1, 2'd1, 64'h0000_0004, 64'h8000);
    req("R2 ext ip", 1, 5'd0, 64'hDEAD, 5'd2, 64'h10, 2'd1, 2'd0, 64'h0, 64'h8000);
    // R3: zero index register gives no index term
    req("R3 idx zero", 1, 5'd5, 64'h2000, 5'd0, 64'hFFFF_FFFF, 2'd3, 2'd0, 64'h0, 64'h0);
    // R4: every scale code
    for (int s = 0; s < 4; s++)
      req("R4 scale", 1, 5'd5, 64'h100, 5'd6, 64'h3, 2'(s), 2'd0, 64'h0, 64'h0);
    // R5/R6: 32-bit negative displacement, 64-bit displacement
    req("R5 d32 neg", 1, 5'd5, 64'h1_0000_0000, 5'd0, 64'h0, 2'd0, 2'd1, 64'hFFFF_FFFF_8000_0000, 64'h0);
    req("R5 d64", 1, 5'd5, 64'h1, 5'd0, 64'h0, 2'd0, 2'd3, 64'h1234_5678_9ABC_DEF0, 64'h0);
    // R7: wrap past the top of the address space
    req("R7 wrap", 1, 5'd9, 64'hFFFF_FFFF_FFFF_FFF0, 5'd3, 64'h8000_0000_0000_0001, 2'd1, 2'd2, 64'h20, 64'h0);

    // R8: idle cycle drops valid and holds the result
    held_ea = ea; held_ip = ip_rel;
    @(negedge clk);
    in_valid = 0; base_spec = 0; ip = 64'h7777; ext_form = 0; disp_word = 64'h1;
    @(negedge clk);
    chk("R8 idle valid", {63'd0, out_valid}, 64'd0);
    chk("R8 idle ea hold", ea, held_ea);
    chk("R8 idle ip_rel hold", {63'd0, ip_rel}, {63'd0, held_ip});

    // Random mix of forms, specifiers, scales and displacement sizes
    for (int n = 0; n < 400; n++) begin
      logic [63:0] bv;
      bv = {$urandom, $urandom};
      if (n % 8 == 0) bv = 64'hFFFF_FFFF_FFFF_FF00 | 64'($urandom % 256);
      req("R1-7 random", 1'($urandom), rspec(), bv, rspec(),
          {$urandom, $urandom}, 2'($urandom), 2'($urandom),
          {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule